// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Latched Error Status

This block receives characters from an asynchronous serial line. A programmable divider produces a sampling tick at sixteen times the bit rate. The receiver watches the synchronized line for a high-to-low transition and confirms the start bit with a sample near its middle. It then takes each later bit as the majority of three samples at the bit centre. Characters may be five to eight data bits long, sent least significant bit first. A parity bit, even or odd, is optional, and the character ends with one or two stop bits.

When the last stop bit has been sampled, the character moves into a receive buffer. At that same moment the overrun, framing and parity conditions are evaluated and stored beside it, together with a summary error bit. The host sees data and status in one 16-bit read word. A one-cycle read strobe marks the host's read of the low byte. That strobe frees the buffer and clears all status bits.

Reception is stopped, and the buffer and status reset to zero, whenever the enable input is low or the mode input holds the off value. An active-low ready output tells a remote sender when the receiver can take a new character.

Top module: `uart_rx_errlatch`

## Requirements
- R1: Data bits are taken least significant first into `rd_word_o[7:0]`. The count of data bits is set by `len_i`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper data bits read as zero. Every character that is not an overrun raises `rx_req_o` for exactly one clock.
- R2: The sampling tick occurs once every `baud_div_i`+1 clocks, and one bit lasts 16 ticks. A low level that has gone high again by the half-bit confirmation sample is discarded, with no request and no change to the read word.
- R3: Each data, parity and stop bit takes the majority value of three samples on consecutive ticks at the bit centre. A single-tick disturbance inside a bit does not change the received value.
- R4: `par_i` = 0x turns parity off, 10 selects even parity and 11 selects odd parity. When the ones in the data bits plus the parity bit break the selected rule, `rd_word_o[14]` is set.
- R5: `two_stop_i` selects one stop bit (0) or two stop bits (1). If any of the expected stop bits is sampled low, `rd_word_o[13]` is set.
- R6: A character that completes while the buffer still holds an unread character sets `rd_word_o[12]`. The new character still replaces the old data, and no request pulse is raised for it.
- R7: `rd_word_o[15]` is set exactly when at least one of bits 12, 13 and 14 is set. It returns to 0 only when all three are clear.
- R8: Status bits change only when a character enters the buffer, when the read strobe arrives, or when reception is turned off. A pulse on `rd_lo_i` clears bits 15:12 and keeps the data byte.
- R9: While `rx_en_i` is 0 or `mode_i` is 3'b000, the read word reads zero, line activity is ignored and no request is raised.
- R10: `rts_n_o` is low while reception is on and the receiver is idle or checking a start bit. It goes high on the tick that confirms a start bit and stays high until the last stop bit has been sampled. It is high whenever reception is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Reception enable; 0 stops reception and clears buffer and status |
| mode_i | input | 3 | Mode select; 3'b000 is off, any other value runs the receiver |
| len_i | input | 2 | Data length code (5 to 8 bits) |
| par_i | input | 2 | Parity control: bit 1 enables, bit 0 selects odd |
| two_stop_i | input | 1 | 1 = two stop bits expected |
| baud_div_i | input | DIV_W | Tick divider; tick period is value + 1 clocks |
| rx_i | input | 1 | Serial line, idle high |
| rd_lo_i | input | 1 | One-cycle strobe: host has read the low byte |
| rd_word_o | output | 16 | {sum, parity, framing, overrun, 4'b0, data[7:0]} |
| rx_req_o | output | 1 | One-cycle receive-complete request |
| rts_n_o | output | 1 | Active-low ready-to-receive |

## Verification
On every clock the assertions check the following. The summary bit always equals the OR of the three error bits. A transfer into an unread buffer sets the overrun bit and gives no request. A request never lasts more than one clock. The read strobe clears the status, and status and data stay put between events. Turning reception off empties the read word, and the ready line rises only after a confirmed start.

Other behaviour can only be shown by the bench scenarios, because only they know which serial waveform was sent. This covers bit ordering across the four lengths, parity and stop-bit judgement, majority filtering of a narrow spike, rejection of a short glitch, and operation at a slower divider.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int OVS      = 16;
  localparam int CNT_W    = $clog2(OVS);
  localparam int DATA_MAX = 8;
  localparam int IDX_W    = $clog2(DATA_MAX);
  localparam int WORD_W   = 16;
  localparam int POS_OVR  = 12;
  localparam int POS_FE   = 13;
  localparam int POS_PE   = 14;
  localparam int POS_SUM  = 15;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP1, PH_STOP2
  } phase_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic [3:0] data_len(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // even rule: total ones even; odd rule: total ones odd
  function automatic logic parity_bad(input logic [DATA_MAX-1:0] d,
                                      input logic p, input logic odd);
    return ((^d) ^ p) != odd;
  endfunction
endpackage

// File: rtl/srx_baud_tick.sv
module srx_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt >= div);
  assign tick = run && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || wrap) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/srx_sampler.sv
module srx_sampler
  import srx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                tick,
  input  logic                rx_i,
  input  logic [1:0]          len_code,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                two_stop,
  output logic                done,
  output logic [DATA_MAX-1:0] frame_data,
  output logic                frame_fe,
  output logic                frame_pe,
  output logic                busy,
  output logic                start_ok
);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(OVS - 1);

  logic                sync1, sync2, rx_s;
  logic [1:0]          hist;
  phase_t              ph;
  logic [CNT_W-1:0]    cnt;
  logic [IDX_W-1:0]    idx;
  logic [DATA_MAX-1:0] shreg;
  logic                pbit, fe_acc;
  logic                center, bit_val, fall_seen, start_bad, last_stop, last_data;

  assign rx_s      = sync2;
  assign bit_val   = maj3(hist[1], hist[0], rx_s);
  assign fall_seen = tick && (ph == PH_IDLE) && hist[0] && !rx_s;
  assign start_ok  = tick && (ph == PH_START) && (cnt == HALF_M1) && !rx_s;
  assign start_bad = tick && (ph == PH_START) && (cnt == HALF_M1) && rx_s;
  assign center    = tick && (ph inside {PH_DATA, PH_PAR, PH_STOP1, PH_STOP2})
                     && (cnt == LAST);
  assign last_stop = center && (((ph == PH_STOP1) && !two_stop) || (ph == PH_STOP2));
  assign last_data = (idx == IDX_W'(data_len(len_code) - 4'd1));
  assign busy      = (ph != PH_IDLE) && (ph != PH_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= rx_i;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      idx    <= '0;
      hist   <= 2'b11;
      shreg  <= '0;
      pbit   <= 1'b0;
      fe_acc <= 1'b0;
    end else if (!run) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      idx    <= '0;
      hist   <= 2'b11;
      fe_acc <= 1'b0;
    end else begin
      if (tick) hist <= {hist[0], rx_s};
      unique case (ph)
        PH_IDLE: begin
          if (fall_seen) begin
            ph  <= PH_START;
            cnt <= '0;
          end
        end
        PH_START: begin
          if (start_ok) begin
            ph     <= PH_DATA;
            cnt    <= '0;
            idx    <= '0;
            shreg  <= '0;
            pbit   <= 1'b0;
            fe_acc <= 1'b0;
          end else if (start_bad) begin
            ph <= PH_IDLE;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (center) cnt <= '0;
          else if (tick) cnt <= cnt + 1'b1;
          if (center) begin
            case (ph)
              PH_DATA: begin
                shreg[idx] <= bit_val;
                if (last_data) ph <= par_en ? PH_PAR : PH_STOP1;
                else idx <= idx + 1'b1;
              end
              PH_PAR: begin
                pbit <= bit_val;
                ph   <= PH_STOP1;
              end
              PH_STOP1: begin
                fe_acc <= !bit_val;
                ph     <= two_stop ? PH_STOP2 : PH_IDLE;
              end
              default: ph <= PH_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      frame_data <= '0;
      frame_fe   <= 1'b0;
      frame_pe   <= 1'b0;
    end else begin
      done <= run && last_stop;
      if (run && last_stop) begin
        frame_data <= shreg;
        frame_fe   <= fe_acc | !bit_val;
        frame_pe   <= par_en && parity_bad(shreg, pbit, par_odd);
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done held");                          // R1
  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ph == PH_IDLE) else $error("done outside idle");          // R5
endmodule

// File: rtl/srx_rxbuf.sv
module srx_rxbuf
  import srx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                done,
  input  logic [DATA_MAX-1:0] data_in,
  input  logic                fe_in,
  input  logic                pe_in,
  input  logic                rd_lo,
  output logic [WORD_W-1:0]   word,
  output logic                req
);
  logic [DATA_MAX-1:0] dat;
  logic                full, ovr, fe, pe, sum;
  logic                ovr_now;

  assign ovr_now = full && !rd_lo;

  always_comb begin
    word           = '0;
    word[DATA_MAX-1:0] = dat;
    word[POS_OVR]  = ovr;
    word[POS_FE]   = fe;
    word[POS_PE]   = pe;
    word[POS_SUM]  = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat <= '0; full <= 1'b0; ovr <= 1'b0; fe <= 1'b0; pe <= 1'b0;
      sum <= 1'b0; req <= 1'b0;
    end else if (!run) begin
      dat <= '0; full <= 1'b0; ovr <= 1'b0; fe <= 1'b0; pe <= 1'b0;
      sum <= 1'b0; req <= 1'b0;
    end else if (done) begin
      dat  <= data_in;
      full <= 1'b1;
      ovr  <= ovr_now;
      fe   <= fe_in;
      pe   <= pe_in;
      sum  <= ovr_now | fe_in | pe_in;
      req  <= !ovr_now;
    end else begin
      req <= 1'b0;
      if (rd_lo) begin
        full <= 1'b0; ovr <= 1'b0; fe <= 1'b0; pe <= 1'b0; sum <= 1'b0;
      end
    end
  end

  AST_SUM_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    sum == (ovr | fe | pe)) else $error("sum mismatch");                  // R7
  AST_OVR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (run && done && full && !rd_lo) |=> (!req && ovr)) else $error("overrun"); // R6
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req) else $error("req held");                                // R1
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rd_lo && !done) |=> (!ovr && !fe && !pe && !full)) else $error("read"); // R8
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run && !done && !rd_lo)) |-> $stable({dat, ovr, fe, pe}))
    else $error("status moved");                                          // R8
endmodule

// File: rtl/uart_rx_errlatch.sv
module uart_rx_errlatch
  import srx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en_i,
  input  logic [2:0]        mode_i,
  input  logic [1:0]        len_i,
  input  logic [1:0]        par_i,
  input  logic              two_stop_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic              rx_i,
  input  logic              rd_lo_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              rx_req_o,
  output logic              rts_n_o
);
  logic                run, tick, done, fe, pe, busy, start_ok;
  logic [DATA_MAX-1:0] fdata;

  assign run     = rx_en_i && (mode_i != 3'b000);
  assign rts_n_o = !(run && !busy);

  srx_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .div(baud_div_i), .tick(tick)
  );

  srx_sampler u_samp (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .rx_i(rx_i),
    .len_code(len_i), .par_en(par_i[1]), .par_odd(par_i[0]),
    .two_stop(two_stop_i), .done(done), .frame_data(fdata),
    .frame_fe(fe), .frame_pe(pe), .busy(busy), .start_ok(start_ok)
  );

  srx_rxbuf u_buf (
    .clk(clk), .rst_n(rst_n), .run(run), .done(done), .data_in(fdata),
    .fe_in(fe), .pe_in(pe), .rd_lo(rd_lo_i), .word(rd_word_o), .req(rx_req_o)
  );

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (rd_word_o == '0 && !rx_req_o)) else $error("off not clear"); // R9
  AST_RTS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rts_n_o) && run && $past(run)) |-> $past(start_ok))
    else $error("rts rose without start");                                 // R10
endmodule

// File: tb/tb_uart_rx_errlatch.sv
module tb_uart_rx_errlatch;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 16;
  localparam int NVEC = 9;
  // {len, par, two_stop, bad_par, bad_stop, 1'b0, data, expected word}
  localparam logic [31:0] VEC [NVEC] = '{
    {2'd3, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 16'h00A5},
    {2'd0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 16'h001F},
    {2'd1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h2B, 16'h002B},
    {2'd2, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 8'h55, 16'h0055},
    {2'd3, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h81, 16'hC081},
    {2'd3, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C, 16'hA03C},
    {2'd3, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 16'hA000},
    {2'd2, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 8'h7F, 16'hE07F},
    {2'd0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0A, 16'h000A}
  };

  logic clk = 1'b0;
  logic rst_n, rx_en, two_stop, rx, rd_lo, req, rts_n;
  logic [2:0] mode;
  logic [1:0] len, par;
  logic [DIV_W-1:0] div;
  logic [15:0] word;
  int checks = 0;
  int fails = 0;
  int req_cnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_errlatch #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en), .mode_i(mode), .len_i(len),
    .par_i(par), .two_stop_i(two_stop), .baud_div_i(div), .rx_i(rx),
    .rd_lo_i(rd_lo), .rd_word_o(word), .rx_req_o(req), .rts_n_o(rts_n)
  );

  always @(negedge clk) if (req === 1'b1) req_cnt++;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_read();
    rd_lo = 1'b1; clks(1); rd_lo = 1'b0; clks(2);
  endtask

  task automatic send(input logic [1:0] l, input logic [1:0] p, input logic two,
                      input logic [7:0] d, input logic bad_p, input logic bad_s,
                      input int spike_bit, input bit chk_rts);
    int bp = 16 * (int'(div) + 1);
    int n = 5 + int'(l);
    logic [7:0] dm = d & ((8'h1 << n) - 8'h1);
    logic pb = (^dm) ^ p[0] ^ bad_p;
    rx = 1'b0; clks(bp);
    for (int i = 0; i < n; i++) begin
      rx = d[i];
      if (i == spike_bit) begin
        clks(7); rx = ~d[i]; clks(1); rx = d[i]; clks(bp - 8);
      end else if (chk_rts && i == 2) begin
        clks(bp / 2);
        chk("R10 rts high mid-frame", {15'h0, rts_n}, 16'h1);
        clks(bp - bp / 2);
      end else clks(bp);
    end
    if (p[1]) begin rx = pb; clks(bp); end
    rx = !bad_s; clks(bp);
    if (two) begin rx = 1'b1; clks(bp); end
    rx = 1'b1; clks(2 * bp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int r;
    rst_n = 1'b0; rx_en = 1'b1; mode = 3'b001; len = 2'd3; par = 2'b00;
    two_stop = 1'b0; div = '0; rx = 1'b1; rd_lo = 1'b0;
    clks(4); rst_n = 1'b1; clks(3);
    chk("R9 reset word", word, 16'h0000);
    chk("R10 reset rts low", {15'h0, rts_n}, 16'h0);
    chk("R1 reset no request", {15'h0, req}, 16'h0);

    for (int v = 0; v < NVEC; v++) begin
      len = VEC[v][31:30]; par = VEC[v][29:28]; two_stop = VEC[v][27];
      r = req_cnt;
      send(VEC[v][31:30], VEC[v][29:28], VEC[v][27], VEC[v][23:16],
           VEC[v][26], VEC[v][25], -1, 1'b0);
      chk("R1 R4 R5 R7 vector word", word, VEC[v][15:0]);
      chk("R1 vector request count", 16'(req_cnt - r), 16'd1);
      host_read();
      chk("R8 read clears status", word, VEC[v][15:0] & 16'h00FF);
    end

    len = 2'd3; par = 2'b00; two_stop = 1'b0;
    send(2'd3, 2'b00, 1'b0, 8'hA5, 1'b0, 1'b0, 0, 1'b0);
    chk("R3 spike filtered", word, 16'h00A5);
    host_read();

    r = req_cnt;
    rx = 1'b0; clks(3); rx = 1'b1; clks(40);
    chk("R2 glitch ignored word", word, 16'h00A5);
    chk("R2 glitch no request", 16'(req_cnt - r), 16'd0);

    div = 16'd2; r = req_cnt;
    send(2'd3, 2'b00, 1'b0, 8'h3C, 1'b0, 1'b0, -1, 1'b1);
    chk("R2 slow divider word", word, 16'h003C);
    chk("R2 slow divider request", 16'(req_cnt - r), 16'd1);
    chk("R10 rts low after frame", {15'h0, rts_n}, 16'h0);
    host_read();
    div = '0;

    r = req_cnt;
    send(2'd3, 2'b00, 1'b0, 8'h11, 1'b0, 1'b0, -1, 1'b0);
    send(2'd3, 2'b00, 1'b0, 8'h22, 1'b0, 1'b0, -1, 1'b0);
    chk("R6 R7 overrun word", word, 16'h9022);
    chk("R6 overrun no request", 16'(req_cnt - r), 16'd1);
    host_read();
    chk("R7 sum cleared", word, 16'h0022);
    send(2'd3, 2'b00, 1'b0, 8'h33, 1'b0, 1'b0, -1, 1'b0);
    chk("R8 no stale flags", word, 16'h0033);
    host_read();

    par = 2'b10;
    send(2'd3, 2'b10, 1'b0, 8'h44, 1'b1, 1'b0, -1, 1'b0);
    chk("R4 parity error word", word, 16'hC044);
    rx_en = 1'b0; clks(3);
    chk("R9 disable clears", word, 16'h0000);
    chk("R10 rts high when off", {15'h0, rts_n}, 16'h1);
    r = req_cnt;
    send(2'd3, 2'b10, 1'b0, 8'h5A, 1'b0, 1'b0, -1, 1'b0);
    chk("R9 frame ignored when off", word, 16'h0000);
    chk("R9 no request when off", 16'(req_cnt - r), 16'd0);
    rx_en = 1'b1; clks(3);
    chk("R10 rts low re-enabled", {15'h0, rts_n}, 16'h0);
    send(2'd3, 2'b10, 1'b0, 8'h66, 1'b1, 1'b0, -1, 1'b0);
    mode = 3'b000; clks(3);
    chk("R9 mode off clears", word, 16'h0000);
    mode = 3'b001; clks(3);
    send(2'd3, 2'b10, 1'b0, 8'h0F, 1'b0, 1'b0, -1, 1'b0);
    chk("R9 R4 receive after re-enable", word, 16'h000F);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule